// File: doc/BRIEF.md
# DMA channel layer control registers

This block is the register bank that controls a multi-channel DMA layer feeding network MACs. It answers a simple register bus at fixed word addresses. It holds a configuration word, an error status word, an interrupt enable word, and for each direction an active-set word, an active-reset word, an end-of-buffer status word and a descriptor-error status word. It also stores one descriptor table pointer per transmit channel and, per receive channel, a table pointer and a buffer size. The channel counts are parameters.

Status words are cleared by writing ones. The DMA engines raise status bits through set inputs; here those inputs also serve for test. Writing the configuration word with its top bit set first returns the control and status words to their reset values. Four interrupt lines are formed from the status words, each gated by its own enable bit. Reads are combinational from the address; writes take effect on the clock edge where `reg_wr` is high.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset the configuration word (0x180) reads 0x0007C000. Every other address reads zero, including all channel pointers and buffer sizes.
- R2: A write stores the value masked as follows, and a read at the same address returns it: configuration 0x180 mask 0x00FFC087 (when bit 31 of the written value is clear), interrupt enable 0x182 mask 0x0000001F, transmit active set/reset 0x184/0x185 mask 0xF0000000, receive active set/reset 0x190/0x191 mask 0xC0000000.
- R3: Status words at 0x181 (error), 0x186 (transmit end-of-buffer), 0x187 (transmit descriptor error), 0x192 (receive end-of-buffer) and 0x193 (receive descriptor error) clear exactly the bits written as 1 and keep the rest.
- R4: A bit on a set input is OR-ed into its status word on that clock edge. When a set and a clearing write hit the same bit in the same cycle, the set wins. Set bits accumulate over cycles.
- R5: A configuration write with bit 31 set returns the error, enable, active and status words to zero. The configuration word then holds the written value AND 0x00FFC087, so bit 31 reads back as 0.
- R6: The bit-31 self-reset leaves the channel pointers and buffer sizes unchanged.
- R7: Transmit channel i (0 <= i < TX_CH) has a full 32-bit table pointer at 0x1A0+i.
- R8: Receive channel i (0 <= i < RX_CH) has a full 32-bit table pointer at 0x1C0+i and a buffer size at 0x1E0+i with write mask 0x000000FF.
- R9: Any address not listed above, including addresses just past each channel window, reads zero. Writes to such addresses change no register.
- R10: The interrupt outputs are enable bit 0 AND (error word nonzero) for irq_err, bit 1 AND (transmit end-of-buffer nonzero) for irq_txeob, bit 2 AND (receive end-of-buffer nonzero) for irq_rxeob, and bit 3 AND (either descriptor-error word nonzero) for irq_desc. Each follows the register state with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| set_err | input | 32 | Error status set bits |
| set_txeob | input | 32 | Transmit end-of-buffer set bits |
| set_txde | input | 32 | Transmit descriptor-error set bits |
| set_rxeob | input | 32 | Receive end-of-buffer set bits |
| set_rxde | input | 32 | Receive descriptor-error set bits |
| irq_err | output | 1 | Error interrupt |
| irq_txeob | output | 1 | Transmit end-of-buffer interrupt |
| irq_rxeob | output | 1 | Receive end-of-buffer interrupt |
| irq_desc | output | 1 | Descriptor-error interrupt |

## Verification
A status set from the engine side and a write-one-to-clear from the bus can hit the same bit on the same edge. The bench provokes this by raising a set input in the very cycle it writes ones to that status word. It then expects only the newly set bit to survive. The same collision is covered for the self-reset: status bits set earlier must read zero after a bit-31 configuration write, while the channel pointers written before it must read back unchanged.

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs #(
  parameter int TX_CH  = 4,
  parameter int RX_CH  = 2,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       set_err,
  input  logic [31:0]       set_txeob,
  input  logic [31:0]       set_txde,
  input  logic [31:0]       set_rxeob,
  input  logic [31:0]       set_rxde,
  output logic              irq_err,
  output logic              irq_txeob,
  output logic              irq_rxeob,
  output logic              irq_desc
);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(10'h180);
  localparam logic [ADDR_W-1:0] A_ERR   = ADDR_W'(10'h181);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(10'h182);
  localparam logic [ADDR_W-1:0] A_TXAS  = ADDR_W'(10'h184);
  localparam logic [ADDR_W-1:0] A_TXAR  = ADDR_W'(10'h185);
  localparam logic [ADDR_W-1:0] A_TXEOB = ADDR_W'(10'h186);
  localparam logic [ADDR_W-1:0] A_TXDE  = ADDR_W'(10'h187);
  localparam logic [ADDR_W-1:0] A_RXAS  = ADDR_W'(10'h190);
  localparam logic [ADDR_W-1:0] A_RXAR  = ADDR_W'(10'h191);
  localparam logic [ADDR_W-1:0] A_RXEOB = ADDR_W'(10'h192);
  localparam logic [ADDR_W-1:0] A_RXDE  = ADDR_W'(10'h193);
  localparam int TXP_BASE = 'h1A0;
  localparam int RXP_BASE = 'h1C0;
  localparam int RBS_BASE = 'h1E0;
  localparam logic [31:0] CFG_RST  = 32'h0007_C000;
  localparam logic [31:0] CFG_MASK = 32'h00FF_C087;
  localparam logic [31:0] IEN_MASK = 32'h0000_001F;
  localparam logic [31:0] TXA_MASK = 32'hF000_0000;
  localparam logic [31:0] RXA_MASK = 32'hC000_0000;
  localparam logic [31:0] RBS_MASK = 32'h0000_00FF;

  if (TX_CH < 1 || TX_CH > 32 || RX_CH < 1 || RX_CH > 32) begin : g_bad_cnt
    $error("channel counts must lie in 1..32");
  end

  logic [31:0] cfg_q, err_q, ien_q, txas_q, txar_q, txeob_q, txde_q;
  logic [31:0] rxas_q, rxar_q, rxeob_q, rxde_q;
  logic [31:0] txp_q [TX_CH];
  logic [31:0] rxp_q [RX_CH];
  logic [31:0] rbs_q [RX_CH];

  wire soft_rst = reg_wr && reg_addr == A_CFG && reg_wdata[31];

  function automatic logic [31:0] clr_of(input logic we, input logic [31:0] d);
    return we ? d : 32'h0;
  endfunction

  wire [31:0] clr_err   = clr_of(reg_wr && reg_addr == A_ERR,   reg_wdata);
  wire [31:0] clr_txeob = clr_of(reg_wr && reg_addr == A_TXEOB, reg_wdata);
  wire [31:0] clr_txde  = clr_of(reg_wr && reg_addr == A_TXDE,  reg_wdata);
  wire [31:0] clr_rxeob = clr_of(reg_wr && reg_addr == A_RXEOB, reg_wdata);
  wire [31:0] clr_rxde  = clr_of(reg_wr && reg_addr == A_RXDE,  reg_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      err_q   <= '0;
      ien_q   <= '0;
      txas_q  <= '0;
      txar_q  <= '0;
      txeob_q <= '0;
      txde_q  <= '0;
      rxas_q  <= '0;
      rxar_q  <= '0;
      rxeob_q <= '0;
      rxde_q  <= '0;
    end else if (soft_rst) begin
      cfg_q   <= reg_wdata & CFG_MASK;
      err_q   <= set_err;
      ien_q   <= '0;
      txas_q  <= '0;
      txar_q  <= '0;
      txeob_q <= set_txeob;
      txde_q  <= set_txde;
      rxas_q  <= '0;
      rxar_q  <= '0;
      rxeob_q <= set_rxeob;
      rxde_q  <= set_rxde;
    end else begin
      if (reg_wr && reg_addr == A_CFG)  cfg_q  <= reg_wdata & CFG_MASK;
      if (reg_wr && reg_addr == A_IEN)  ien_q  <= reg_wdata & IEN_MASK;
      if (reg_wr && reg_addr == A_TXAS) txas_q <= reg_wdata & TXA_MASK;
      if (reg_wr && reg_addr == A_TXAR) txar_q <= reg_wdata & TXA_MASK;
      if (reg_wr && reg_addr == A_RXAS) rxas_q <= reg_wdata & RXA_MASK;
      if (reg_wr && reg_addr == A_RXAR) rxar_q <= reg_wdata & RXA_MASK;
      err_q   <= (err_q   & ~clr_err)   | set_err;
      txeob_q <= (txeob_q & ~clr_txeob) | set_txeob;
      txde_q  <= (txde_q  & ~clr_txde)  | set_txde;
      rxeob_q <= (rxeob_q & ~clr_rxeob) | set_rxeob;
      rxde_q  <= (rxde_q  & ~clr_rxde)  | set_rxde;
    end
  end

  for (genvar i = 0; i < TX_CH; i++) begin : g_tx
    localparam logic [ADDR_W-1:0] A_P = ADDR_W'(TXP_BASE + i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) txp_q[i] <= '0;
      else if (reg_wr && reg_addr == A_P) txp_q[i] <= reg_wdata;
    end
  end

  for (genvar i = 0; i < RX_CH; i++) begin : g_rx
    localparam logic [ADDR_W-1:0] A_P = ADDR_W'(RXP_BASE + i);
    localparam logic [ADDR_W-1:0] A_S = ADDR_W'(RBS_BASE + i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rxp_q[i] <= '0;
        rbs_q[i] <= '0;
      end else if (reg_wr) begin
        if (reg_addr == A_P) rxp_q[i] <= reg_wdata;
        if (reg_addr == A_S) rbs_q[i] <= reg_wdata & RBS_MASK;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = cfg_q;
      A_ERR:   reg_rdata = err_q;
      A_IEN:   reg_rdata = ien_q;
      A_TXAS:  reg_rdata = txas_q;
      A_TXAR:  reg_rdata = txar_q;
      A_TXEOB: reg_rdata = txeob_q;
      A_TXDE:  reg_rdata = txde_q;
      A_RXAS:  reg_rdata = rxas_q;
      A_RXAR:  reg_rdata = rxar_q;
      A_RXEOB: reg_rdata = rxeob_q;
      A_RXDE:  reg_rdata = rxde_q;
      default: reg_rdata = '0;
    endcase
    for (int i = 0; i < TX_CH; i++)
      if (reg_addr == ADDR_W'(TXP_BASE + i)) reg_rdata = txp_q[i];
    for (int i = 0; i < RX_CH; i++) begin
      if (reg_addr == ADDR_W'(RXP_BASE + i)) reg_rdata = rxp_q[i];
      if (reg_addr == ADDR_W'(RBS_BASE + i)) reg_rdata = rbs_q[i];
    end
  end

  assign irq_err   = ien_q[0] & (|err_q);
  assign irq_txeob = ien_q[1] & (|txeob_q);
  assign irq_rxeob = ien_q[2] & (|rxeob_q);
  assign irq_desc  = ien_q[3] & ((|txde_q) | (|rxde_q));
endmodule

module dma_ctl_regs_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [31:0]       set_err,
  input logic [31:0]       set_txeob,
  input logic [31:0]       err_q,
  input logic [31:0]       ien_q,
  input logic [31:0]       txeob_q,
  input logic [31:0]       cfg_q,
  input logic              irq_err
);
  AST_IEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ien_q[31:5] == 27'h0); // R2
  AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(10'h181) && set_err == 32'h0)
    |=> err_q == ($past(err_q) & ~$past(reg_wdata))); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_txeob != 32'h0) |=> (txeob_q & $past(set_txeob)) == $past(set_txeob)); // R4
  AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(10'h180) && reg_wdata[31])
    |=> (ien_q == 32'h0 && cfg_q == ($past(reg_wdata) & 32'h00FF_C087))); // R5
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(10'h183)) |-> reg_rdata == 32'h0); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_q[0] || err_q == 32'h0) |-> !irq_err); // R10
endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_err(set_err),
  .set_txeob(set_txeob), .err_q(err_q), .ien_q(ien_q), .txeob_q(txeob_q),
  .cfg_q(cfg_q), .irq_err(irq_err)
);

// File: tb/sim_dma_ctl_regs.sv
`timescale 1ns/1ps
module sim_dma_ctl_regs;
  localparam int TXN = 4;
  localparam int RXN = 2;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [9:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [31:0] set_err = '0, set_txeob = '0, set_txde = '0, set_rxeob = '0, set_rxde = '0;
  logic irq_err, irq_txeob, irq_rxeob, irq_desc;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_ctl_regs #(.TX_CH(TXN), .RX_CH(RXN), .ADDR_W(10)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_err(set_err),
    .set_txeob(set_txeob), .set_txde(set_txde), .set_rxeob(set_rxeob),
    .set_rxde(set_rxde), .irq_err(irq_err), .irq_txeob(irq_txeob),
    .irq_rxeob(irq_rxeob), .irq_desc(irq_desc));

  function automatic logic [31:0] mask_of(input int a);
    if (a == 'h180) return 32'h00FF_C087;
    if (a == 'h182) return 32'h0000_001F;
    if (a == 'h184 || a == 'h185) return 32'hF000_0000;
    if (a == 'h190 || a == 'h191) return 32'hC000_0000;
    if (a >= 'h1A0 && a < 'h1A0 + TXN) return 32'hFFFF_FFFF;
    if (a >= 'h1C0 && a < 'h1C0 + RXN) return 32'hFFFF_FFFF;
    if (a >= 'h1E0 && a < 'h1E0 + RXN) return 32'h0000_00FF;
    return 32'h0;
  endfunction

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h9E37_79B1 + 32'h1234_5678) & 32'h7FFF_FFFF;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 10'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 10'(a);
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [31:0] e, input logic [31:0] te, input logic [31:0] td,
                       input logic [31:0] re, input logic [31:0] rde);
    @(negedge clk);
    set_err = e; set_txeob = te; set_txde = td; set_rxeob = re; set_rxde = rde;
    @(negedge clk);
    set_err = 0; set_txeob = 0; set_txde = 0; set_rxeob = 0; set_rxde = 0;
  endtask

  task automatic irqs(input logic [3:0] exp, input string tag);
    @(negedge clk);
    #1 check(tag, {28'h0, irq_desc, irq_rxeob, irq_txeob, irq_err}, {28'h0, exp});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int sts [5] = '{'h181, 'h186, 'h187, 'h192, 'h193};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values over the whole map and surroundings
    for (int a = 'h100; a < 'h240; a++) begin
      rd(a, d);
      check("R1 reset", d, a == 'h180 ? 32'h0007_C000 : 32'h0);
    end
    irqs(4'h0, "R1 irq reset");
    // R2 R7 R8 R9: write every address, read back immediately
    for (int a = 'h100; a < 'h240; a++) begin
      wr(a, pat(a));
      rd(a, d);
      check("R2/R7/R8/R9 write-read", d, pat(a) & mask_of(a));
    end
    // R9: later writes to holes altered nothing written earlier
    for (int a = 'h100; a < 'h240; a++) begin
      rd(a, d);
      check("R9 isolation", d, pat(a) & mask_of(a));
    end
    // R3 write-one-to-clear on each status word
    wr('h182, 0);
    pulse(32'hF0F0_00FF, 32'hF0F0_00FF, 32'hF0F0_00FF, 32'hF0F0_00FF, 32'hF0F0_00FF);
    foreach (sts[k]) begin
      rd(sts[k], d);
      check("R3 set", d, 32'hF0F0_00FF);
      wr(sts[k], 32'h00F0_000F);
      rd(sts[k], d);
      check("R3 clear", d, 32'hF000_00F0);
      wr(sts[k], 32'hFFFF_FFFF);
      rd(sts[k], d);
      check("R3 clear all", d, 32'h0);
    end
    // R4 accumulation and set-wins collision
    pulse(0, 32'h1, 0, 0, 0);
    pulse(0, 32'h2, 0, 0, 0);
    rd('h186, d);
    check("R4 accumulate", d, 32'h3);
    @(negedge clk);
    reg_wr = 1; reg_addr = 10'h186; reg_wdata = 32'hFFFF_FFFF; set_txeob = 32'h10;
    @(negedge clk);
    reg_wr = 0; set_txeob = 0;
    rd('h186, d);
    check("R4 set wins", d, 32'h10);
    wr('h186, 32'hFFFF_FFFF);
    // R10 interrupt gating, all enable values
    pulse(32'h1, 32'h2, 32'h8, 32'h4, 0);
    for (int v = 0; v < 32; v++) begin
      wr('h182, 32'(v));
      irqs(4'(v), "R10 enable sweep");
    end
    wr('h187, 32'hFFFF_FFFF);
    irqs(4'h7, "R10 txde cleared");
    pulse(0, 0, 0, 0, 32'h100);
    irqs(4'hF, "R10 rxde path");
    wr('h193, 32'h100);
    wr('h181, 32'h1);
    irqs(4'h6, "R10 err/desc cleared");
    // R5 R6 self-reset
    wr('h184, 32'hFFFF_FFFF);
    wr('h191, 32'hFFFF_FFFF);
    pulse(32'h5, 32'h5, 32'h5, 32'h5, 32'h5);
    wr('h180, 32'h8000_0001);
    rd('h180, d);
    check("R5 cfg after self-reset", d, 32'h0000_0001);
    for (int a = 'h181; a < 'h194; a++) begin
      if (a == 'h180) continue;
      rd(a, d);
      check("R5 cleared", d, 32'h0);
    end
    irqs(4'h0, "R5 irq idle");
    for (int a = 'h1A0; a < 'h1F0; a++) begin
      rd(a, d);
      check("R6 kept", d, pat(a) & mask_of(a));
    end
    wr('h180, 32'hFFFF_FFFF);
    rd('h180, d);
    check("R5 full mask", d, 32'h00FF_C087);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule